// File: doc/BRIEF.md
# Local Memory Port Arbiter

This block shares one single-ported, fully pipelined local SRAM of 256 KB among three clients: a bulk-transfer (DMA) engine, the load/store unit and the instruction fetcher. In every cycle it grants the memory to at most one client under a fixed priority. DMA always wins. Load/store comes second, and a blocked load or store simply keeps requesting until a free cycle arrives. Instruction fetch gets the port only on cycles that neither of the others wants. The winning request goes to the SRAM as a single registered command, one per cycle.

DMA and fetch move a whole 128-byte line per access. Load/store moves one 16-byte quadword, written through a per-quadword write mask or picked out of the returned line. Each command slot carries a tag that names its owner and its quadword position. Read data therefore comes back on the right client's port exactly six cycles after the grant, and a new read can start every cycle. A saturating counter reports how many consecutive cycles a pending fetch has been turned away.

The SRAM itself sits outside the block. It must return read data `RD_LAT-2` cycles after it sees a read command.

Top module: `ls_port_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_en`, all three `*_rvalid` outputs and `ifu_starve` are 0.
- R2: Whenever `dma_req` is high, `dma_gnt` is high in the same cycle.
- R3: `lsu_gnt` is high exactly when `lsu_req` is high and `dma_req` is low.
- R4: `ifu_gnt` is high only when `ifu_req` is high and both `dma_req` and `lsu_req` are low. At most one grant is high in any cycle.
- R5: A grant in cycle t puts exactly one command on the memory port in cycle t+1, and a cycle with no grant gives no command.
  - `mem_idx` is address bits [17:7].
  - A line write drives `mem_qmask` to all ones.
  - A quadword write drives only `mem_qmask` bit q, where q is address bits [6:4], and places the data in bits [q*128 +: 128] of `mem_wdata`.
- R6: A read granted in cycle t raises the granted client's `*_rvalid` for one cycle in cycle t+6, with its data. No other client's `*_rvalid` is raised by that read.
- R7: A load/store read returns quadword q (address bits [6:4]) of the addressed line on `lsu_rdata`.
- R8: A granted write never raises any `*_rvalid`.
- R9: The low address bits are ignored: bits [6:0] for DMA and fetch, bits [3:0] for load/store.
- R10: `ifu_starve` rises by one after each cycle in which `ifu_req` is high and not granted. It holds at its all-ones maximum once there. It clears to 0 after a cycle in which fetch is granted or does not request.
- R11: Reads granted on consecutive cycles, from any mix of clients, each return exactly six cycles after their own grant, in grant order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | ADDR_W | DMA byte address |
| dma_wdata | input | LINE_W | DMA line write data |
| dma_gnt | output | 1 | DMA granted this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | LINE_W | DMA read line |
| lsu_req | input | 1 | Load/store request |
| lsu_we | input | 1 | Store (1) or load (0) |
| lsu_addr | input | ADDR_W | Load/store byte address |
| lsu_wdata | input | QUAD_W | Store quadword |
| lsu_gnt | output | 1 | Load/store granted this cycle |
| lsu_rvalid | output | 1 | Load data valid |
| lsu_rdata | output | QUAD_W | Load quadword |
| ifu_req | input | 1 | Fetch request |
| ifu_addr | input | ADDR_W | Fetch byte address |
| ifu_gnt | output | 1 | Fetch granted this cycle |
| ifu_rvalid | output | 1 | Fetch data valid |
| ifu_rdata | output | LINE_W | Fetched line |
| ifu_starve | output | STARVE_W | Consecutive denied fetch cycles |
| mem_en | output | 1 | Memory command valid |
| mem_we | output | 1 | Memory command is a write |
| mem_idx | output | ADDR_W-7 | Line index |
| mem_qmask | output | LINE_BYTES/QUAD_BYTES | Per-quadword write enables |
| mem_wdata | output | LINE_W | Memory write line |
| mem_rdata | input | LINE_W | Memory read line, RD_LAT-2 cycles after command |

## Verification
The assertions check the grant rules on every cycle:
- DMA always wins, load/store wins only when DMA is absent, fetch wins only when the port is otherwise idle, and at most one grant is high.
- A command follows a grant one cycle later.
- The starvation counter increments, saturates and clears as specified.
- Each read's return appears on the right port six cycles after its grant, tracked against a shadow of the grant history.

Only the bench's scenarios can show data-path behaviour: that the returned data is really the addressed line or quadword, that stores merge into one quadword of a line without disturbing the rest, and that low address bits have no effect on which data moves. These need a model of memory contents and a sequence of writes followed by reads.

// File: rtl/ls_arb_pkg.sv
package ls_arb_pkg;

  // Owner of a memory slot; SRC_NONE marks idle slots and writes.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DMA  = 2'd1,
    SRC_LSU  = 2'd2,
    SRC_IFU  = 2'd3
  } src_e;

  // Fixed priority: bulk transfer, then load/store, then fetch.
  function automatic src_e pick_src(input logic d, input logic l, input logic i);
    if (d)      return SRC_DMA;
    else if (l) return SRC_LSU;
    else if (i) return SRC_IFU;
    return SRC_NONE;
  endfunction

endpackage

// File: rtl/ls_arb_select.sv
module ls_arb_select
  import ls_arb_pkg::*;
(
  input  logic dma_req,
  input  logic lsu_req,
  input  logic ifu_req,
  output logic dma_gnt,
  output logic lsu_gnt,
  output logic ifu_gnt,
  output src_e winner
);

  always_comb begin
    winner  = pick_src(dma_req, lsu_req, ifu_req);
    dma_gnt = (winner == SRC_DMA);
    lsu_gnt = (winner == SRC_LSU);
    ifu_gnt = (winner == SRC_IFU);
  end

endmodule

// File: rtl/ls_arb_cmd.sv
module ls_arb_cmd
  import ls_arb_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LINE_W = 1024,
  parameter int QUAD_W = 128,
  parameter int QPL    = 8,
  parameter int LOFF   = 7,
  parameter int QOFF   = 4,
  parameter int QSEL_W = 3,
  parameter int IDX_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  src_e              winner,
  input  logic              dma_we,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [LINE_W-1:0] dma_wdata,
  input  logic              lsu_we,
  input  logic [ADDR_W-1:0] lsu_addr,
  input  logic [QUAD_W-1:0] lsu_wdata,
  input  logic [ADDR_W-1:0] ifu_addr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [QPL-1:0]    mem_qmask,
  output logic [LINE_W-1:0] mem_wdata,
  output src_e              tag_src,
  output logic [QSEL_W-1:0] tag_q
);

  logic              n_en, n_we;
  logic [IDX_W-1:0]  n_idx;
  logic [QPL-1:0]    n_mask;
  logic [LINE_W-1:0] n_wdata;
  src_e              n_src;
  logic [QSEL_W-1:0] n_q;
  logic [QSEL_W-1:0] lsu_q;

  // Offset bits below the access size carry no meaning here.
  logic unused_low_bits;
  assign unused_low_bits = ^{dma_addr[LOFF-1:0], lsu_addr[QOFF-1:0], ifu_addr[LOFF-1:0]};

  assign lsu_q = lsu_addr[LOFF-1:QOFF];

  always_comb begin
    n_en    = 1'b0;
    n_we    = 1'b0;
    n_idx   = '0;
    n_mask  = '0;
    n_wdata = '0;
    n_src   = SRC_NONE;
    n_q     = '0;
    case (winner)
      SRC_DMA: begin
        n_en    = 1'b1;
        n_we    = dma_we;
        n_idx   = dma_addr[ADDR_W-1:LOFF];
        n_mask  = '1;
        n_wdata = dma_wdata;
        n_src   = dma_we ? SRC_NONE : SRC_DMA;
      end
      SRC_LSU: begin
        n_en         = 1'b1;
        n_we         = lsu_we;
        n_idx        = lsu_addr[ADDR_W-1:LOFF];
        n_mask[lsu_q] = 1'b1;
        n_wdata      = {QPL{lsu_wdata}};
        n_src        = lsu_we ? SRC_NONE : SRC_LSU;
        n_q          = lsu_q;
      end
      SRC_IFU: begin
        n_en   = 1'b1;
        n_idx  = ifu_addr[ADDR_W-1:LOFF];
        n_mask = '1;
        n_src  = SRC_IFU;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en  <= 1'b0;
      mem_we  <= 1'b0;
      tag_src <= SRC_NONE;
    end else begin
      mem_en  <= n_en;
      mem_we  <= n_we;
      tag_src <= n_src;
    end
  end

  always_ff @(posedge clk) begin
    mem_idx   <= n_idx;
    mem_qmask <= n_mask;
    mem_wdata <= n_wdata;
    tag_q     <= n_q;
  end

endmodule

// File: rtl/ls_arb_return.sv
module ls_arb_return
  import ls_arb_pkg::*;
#(
  parameter int LINE_W  = 1024,
  parameter int QUAD_W  = 128,
  parameter int QPL     = 8,
  parameter int QSEL_W  = 3,
  parameter int MEM_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  src_e              tag_src,
  input  logic [QSEL_W-1:0] tag_q,
  input  logic [LINE_W-1:0] mem_rdata,
  output logic              dma_rvalid,
  output logic [LINE_W-1:0] dma_rdata,
  output logic              lsu_rvalid,
  output logic [QUAD_W-1:0] lsu_rdata,
  output logic              ifu_rvalid,
  output logic [LINE_W-1:0] ifu_rdata
);

  // Slot tags travel alongside the memory pipeline.
  src_e              stg_src [1:MEM_LAT];
  logic [QSEL_W-1:0] stg_q   [1:MEM_LAT];
  logic [QUAD_W-1:0] quad    [QPL];
  src_e              last_src;
  logic [QSEL_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k <= MEM_LAT; k++) stg_src[k] <= SRC_NONE;
    end else begin
      stg_src[1] <= tag_src;
      for (int k = 2; k <= MEM_LAT; k++) stg_src[k] <= stg_src[k-1];
    end
  end

  always_ff @(posedge clk) begin
    stg_q[1] <= tag_q;
    for (int k = 2; k <= MEM_LAT; k++) stg_q[k] <= stg_q[k-1];
  end

  for (genvar g = 0; g < QPL; g++) begin : g_quad
    assign quad[g] = mem_rdata[g*QUAD_W +: QUAD_W];
  end

  assign last_src = stg_src[MEM_LAT];
  assign last_q   = stg_q[MEM_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_rvalid <= 1'b0;
      lsu_rvalid <= 1'b0;
      ifu_rvalid <= 1'b0;
    end else begin
      dma_rvalid <= (last_src == SRC_DMA);
      lsu_rvalid <= (last_src == SRC_LSU);
      ifu_rvalid <= (last_src == SRC_IFU);
    end
  end

  always_ff @(posedge clk) begin
    if (last_src == SRC_DMA) dma_rdata <= mem_rdata;
    if (last_src == SRC_LSU) lsu_rdata <= quad[last_q];
    if (last_src == SRC_IFU) ifu_rdata <= mem_rdata;
  end

endmodule

// File: rtl/ls_arb_starve.sv
module ls_arb_starve #(
  parameter int STARVE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ifu_req,
  input  logic                ifu_gnt,
  output logic [STARVE_W-1:0] ifu_starve
);

  localparam logic [STARVE_W-1:0] SMAX = '1;

  always_ff @(posedge clk) begin
    if (rst || !ifu_req || ifu_gnt) ifu_starve <= '0;
    else if (ifu_starve != SMAX)    ifu_starve <= ifu_starve + 1'b1;
  end

endmodule

// File: rtl/ls_port_arbiter.sv
module ls_port_arbiter
  import ls_arb_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int LINE_BYTES = 128,
  parameter int QUAD_BYTES = 16,
  parameter int RD_LAT     = 6,
  parameter int STARVE_W   = 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int QUAD_W    = QUAD_BYTES * 8,
  localparam int QPL       = LINE_BYTES / QUAD_BYTES,
  localparam int LOFF      = $clog2(LINE_BYTES),
  localparam int IDX_W     = ADDR_W - LOFF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dma_req,
  input  logic                dma_we,
  input  logic [ADDR_W-1:0]   dma_addr,
  input  logic [LINE_W-1:0]   dma_wdata,
  output logic                dma_gnt,
  output logic                dma_rvalid,
  output logic [LINE_W-1:0]   dma_rdata,
  input  logic                lsu_req,
  input  logic                lsu_we,
  input  logic [ADDR_W-1:0]   lsu_addr,
  input  logic [QUAD_W-1:0]   lsu_wdata,
  output logic                lsu_gnt,
  output logic                lsu_rvalid,
  output logic [QUAD_W-1:0]   lsu_rdata,
  input  logic                ifu_req,
  input  logic [ADDR_W-1:0]   ifu_addr,
  output logic                ifu_gnt,
  output logic                ifu_rvalid,
  output logic [LINE_W-1:0]   ifu_rdata,
  output logic [STARVE_W-1:0] ifu_starve,
  output logic                mem_en,
  output logic                mem_we,
  output logic [IDX_W-1:0]    mem_idx,
  output logic [QPL-1:0]      mem_qmask,
  output logic [LINE_W-1:0]   mem_wdata,
  input  logic [LINE_W-1:0]   mem_rdata
);

  localparam int QOFF    = $clog2(QUAD_BYTES);
  localparam int QSEL_W  = $clog2(QPL);
  localparam int MEM_LAT = RD_LAT - 2;

  src_e              winner;
  src_e              tag_src;
  logic [QSEL_W-1:0] tag_q;

  ls_arb_select u_select (
    .dma_req (dma_req),
    .lsu_req (lsu_req),
    .ifu_req (ifu_req),
    .dma_gnt (dma_gnt),
    .lsu_gnt (lsu_gnt),
    .ifu_gnt (ifu_gnt),
    .winner  (winner)
  );

  ls_arb_cmd #(
    .ADDR_W (ADDR_W), .LINE_W (LINE_W), .QUAD_W (QUAD_W), .QPL (QPL),
    .LOFF (LOFF), .QOFF (QOFF), .QSEL_W (QSEL_W), .IDX_W (IDX_W)
  ) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .winner    (winner),
    .dma_we    (dma_we),
    .dma_addr  (dma_addr),
    .dma_wdata (dma_wdata),
    .lsu_we    (lsu_we),
    .lsu_addr  (lsu_addr),
    .lsu_wdata (lsu_wdata),
    .ifu_addr  (ifu_addr),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_idx   (mem_idx),
    .mem_qmask (mem_qmask),
    .mem_wdata (mem_wdata),
    .tag_src   (tag_src),
    .tag_q     (tag_q)
  );

  ls_arb_return #(
    .LINE_W (LINE_W), .QUAD_W (QUAD_W), .QPL (QPL),
    .QSEL_W (QSEL_W), .MEM_LAT (MEM_LAT)
  ) u_return (
    .clk        (clk),
    .rst        (rst),
    .tag_src    (tag_src),
    .tag_q      (tag_q),
    .mem_rdata  (mem_rdata),
    .dma_rvalid (dma_rvalid),
    .dma_rdata  (dma_rdata),
    .lsu_rvalid (lsu_rvalid),
    .lsu_rdata  (lsu_rdata),
    .ifu_rvalid (ifu_rvalid),
    .ifu_rdata  (ifu_rdata)
  );

  ls_arb_starve #(.STARVE_W (STARVE_W)) u_starve (
    .clk        (clk),
    .rst        (rst),
    .ifu_req    (ifu_req),
    .ifu_gnt    (ifu_gnt),
    .ifu_starve (ifu_starve)
  );

endmodule

// File: rtl/ls_arb_chk.sv
module ls_arb_chk #(
  parameter int RD_LAT   = 6,
  parameter int STARVE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                dma_req,
  input logic                dma_we,
  input logic                dma_gnt,
  input logic                dma_rvalid,
  input logic                lsu_req,
  input logic                lsu_we,
  input logic                lsu_gnt,
  input logic                lsu_rvalid,
  input logic                ifu_req,
  input logic                ifu_gnt,
  input logic                ifu_rvalid,
  input logic [STARVE_W-1:0] ifu_starve,
  input logic                mem_en
);

  localparam logic [STARVE_W-1:0] SMAX = '1;

  // Shadow of read grants, observed at the ports.
  logic [1:0] shd [0:RD_LAT-1];
  logic [1:0] rd_code;
  logic [1:0] shd_last;

  always_comb begin
    rd_code = 2'd0;
    if (dma_gnt && !dma_we)      rd_code = 2'd1;
    else if (lsu_gnt && !lsu_we) rd_code = 2'd2;
    else if (ifu_gnt)            rd_code = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < RD_LAT; k++) shd[k] <= 2'd0;
    end else begin
      shd[0] <= rd_code;
      for (int k = 1; k < RD_LAT; k++) shd[k] <= shd[k-1];
    end
  end

  assign shd_last = shd[RD_LAT-1];

  // R2
  dma_first_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> dma_gnt);

  // R3
  lsu_second_chk: assert property (@(posedge clk) disable iff (rst)
    lsu_gnt |-> (lsu_req && !dma_req));

  // R4
  ifu_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ifu_gnt |-> (ifu_req && !dma_req && !lsu_req));

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dma_gnt, lsu_gnt, ifu_gnt}));

  // R5
  cmd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_gnt || lsu_gnt || ifu_gnt) |=> mem_en);

  // R5
  no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !(dma_gnt || lsu_gnt || ifu_gnt) |=> !mem_en);

  // R6
  dma_ret_chk: assert property (@(posedge clk) disable iff (rst)
    dma_rvalid == (shd_last == 2'd1));

  // R6
  lsu_ret_chk: assert property (@(posedge clk) disable iff (rst)
    lsu_rvalid == (shd_last == 2'd2));

  // R6
  ifu_ret_chk: assert property (@(posedge clk) disable iff (rst)
    ifu_rvalid == (shd_last == 2'd3));

  // R10
  starve_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (ifu_gnt || !ifu_req) |=> (ifu_starve == '0));

  // R10
  starve_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (ifu_req && !ifu_gnt && ifu_starve != SMAX) |=> (ifu_starve == $past(ifu_starve) + 1'b1));

  // R10
  starve_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (ifu_req && !ifu_gnt && ifu_starve == SMAX) |=> (ifu_starve == SMAX));

endmodule

bind ls_port_arbiter ls_arb_chk #(.RD_LAT (RD_LAT), .STARVE_W (STARVE_W)) u_ls_arb_chk (
  .clk        (clk),
  .rst        (rst),
  .dma_req    (dma_req),
  .dma_we     (dma_we),
  .dma_gnt    (dma_gnt),
  .dma_rvalid (dma_rvalid),
  .lsu_req    (lsu_req),
  .lsu_we     (lsu_we),
  .lsu_gnt    (lsu_gnt),
  .lsu_rvalid (lsu_rvalid),
  .ifu_req    (ifu_req),
  .ifu_gnt    (ifu_gnt),
  .ifu_rvalid (ifu_rvalid),
  .ifu_starve (ifu_starve),
  .mem_en     (mem_en)
);

// File: tb/test_ls_port_arbiter.sv
module test_ls_port_arbiter;

  localparam int ADDR_W   = 18;
  localparam int LINE_W   = 1024;
  localparam int QUAD_W   = 128;
  localparam int QPL      = 8;
  localparam int LOFF     = 7;
  localparam int IDX_W    = ADDR_W - LOFF;
  localparam int NLINES   = 1 << IDX_W;
  localparam int RD_LAT   = 6;
  localparam int MEM_LAT  = RD_LAT - 2;
  localparam int STARVE_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic                dma_req = 0, dma_we = 0;
  logic [ADDR_W-1:0]   dma_addr = '0;
  logic [LINE_W-1:0]   dma_wdata = '0;
  logic                dma_gnt, dma_rvalid;
  logic [LINE_W-1:0]   dma_rdata;
  logic                lsu_req = 0, lsu_we = 0;
  logic [ADDR_W-1:0]   lsu_addr = '0;
  logic [QUAD_W-1:0]   lsu_wdata = '0;
  logic                lsu_gnt, lsu_rvalid;
  logic [QUAD_W-1:0]   lsu_rdata;
  logic                ifu_req = 0;
  logic [ADDR_W-1:0]   ifu_addr = '0;
  logic                ifu_gnt, ifu_rvalid;
  logic [LINE_W-1:0]   ifu_rdata;
  logic [STARVE_W-1:0] ifu_starve;
  logic                mem_en, mem_we;
  logic [IDX_W-1:0]    mem_idx;
  logic [QPL-1:0]      mem_qmask;
  logic [LINE_W-1:0]   mem_wdata, mem_rdata;

  ls_port_arbiter i_ls_port_arbiter (.*);

  // Behavioural SRAM with MEM_LAT cycles of read latency.
  logic [LINE_W-1:0] sram    [0:NLINES-1];
  logic [LINE_W-1:0] ref_mem [0:NLINES-1];
  logic [LINE_W-1:0] rd_pipe [0:MEM_LAT-1];

  always @(posedge clk) begin
    logic [LINE_W-1:0] t;
    if (mem_en && mem_we) begin
      t = sram[mem_idx];
      for (int q = 0; q < QPL; q++)
        if (mem_qmask[q]) t[q*QUAD_W +: QUAD_W] = mem_wdata[q*QUAD_W +: QUAD_W];
      sram[mem_idx] <= t;
    end
    if (mem_en && !mem_we) rd_pipe[0] <= sram[mem_idx];
    for (int k = 1; k < MEM_LAT; k++) rd_pipe[k] <= rd_pipe[k-1];
  end
  assign mem_rdata = rd_pipe[MEM_LAT-1];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string what,
                     input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  typedef struct {
    logic [1:0]        src;
    logic [LINE_W-1:0] data;
    int                cyc;
    string             tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [LINE_W-1:0] pattern(input int i);
    logic [LINE_W-1:0] w;
    for (int j = 0; j < LINE_W / 32; j++)
      w[j*32 +: 32] = (i * 32'h01000193) ^ (j * 32'h9E3779B9) ^ 32'h5A5A0000;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] mkaddr(input int line, input int q, input int off);
    return ADDR_W'(line * 128 + q * 16 + off);
  endfunction

  // Next-cycle stimulus, consumed by step().
  bit n_dr, n_dw, n_lr, n_lw, n_ir;
  logic [ADDR_W-1:0] n_da, n_la, n_ia;
  logic [LINE_W-1:0] n_dd;
  logic [QUAD_W-1:0] n_ld;

  task automatic set_dma(input bit we, input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] d);
    n_dr = 1; n_dw = we; n_da = a; n_dd = d;
  endtask
  task automatic set_lsu(input bit we, input logic [ADDR_W-1:0] a, input logic [QUAD_W-1:0] d);
    n_lr = 1; n_lw = we; n_la = a; n_ld = d;
  endtask
  task automatic set_ifu(input logic [ADDR_W-1:0] a);
    n_ir = 1; n_ia = a;
  endtask

  task automatic step(input string tag);
    int w, li, q;
    logic [2:0] eg;
    @(posedge clk); #1;
    dma_req = n_dr; dma_we = n_dw; dma_addr = n_da; dma_wdata = n_dd;
    lsu_req = n_lr; lsu_we = n_lw; lsu_addr = n_la; lsu_wdata = n_ld;
    ifu_req = n_ir; ifu_addr = n_ia;
    @(negedge clk);
    w  = n_dr ? 1 : n_lr ? 2 : n_ir ? 3 : 0;
    eg = (w == 1) ? 3'b100 : (w == 2) ? 3'b010 : (w == 3) ? 3'b001 : 3'b000;
    chk({dma_gnt, lsu_gnt, ifu_gnt} == eg, {tag, " R4 grant"},
        LINE_W'({dma_gnt, lsu_gnt, ifu_gnt}), LINE_W'(eg));
    if (w == 1) begin
      li = int'(n_da[ADDR_W-1:LOFF]);
      if (n_dw) ref_mem[li] = n_dd;
      else sb.push_back('{src: 2'd1, data: ref_mem[li], cyc: cyc + RD_LAT, tag: tag});
    end else if (w == 2) begin
      li = int'(n_la[ADDR_W-1:LOFF]);
      q  = int'(n_la[LOFF-1:4]);
      if (n_lw) ref_mem[li][q*QUAD_W +: QUAD_W] = n_ld;
      else sb.push_back('{src: 2'd2, data: {{(LINE_W-QUAD_W){1'b0}}, ref_mem[li][q*QUAD_W +: QUAD_W]},
                          cyc: cyc + RD_LAT, tag: tag});
    end else if (w == 3) begin
      li = int'(n_ia[ADDR_W-1:LOFF]);
      sb.push_back('{src: 2'd3, data: ref_mem[li], cyc: cyc + RD_LAT, tag: tag});
    end
    n_dr = 0; n_lr = 0; n_ir = 0;
  endtask

  task automatic drain();
    repeat (RD_LAT + 2) step("idle");
  endtask

  // Monitor: pops the scoreboard as returns appear.
  always @(negedge clk) begin
    logic [2:0] v, ev;
    logic [LINE_W-1:0] act;
    exp_t e;
    if (!rst) begin
      v = {dma_rvalid, lsu_rvalid, ifu_rvalid};
      if (sb.size() != 0 && sb[0].cyc == cyc) begin
        e  = sb.pop_front();
        ev = (e.src == 2'd1) ? 3'b100 : (e.src == 2'd2) ? 3'b010 : 3'b001;
        chk(v == ev, {e.tag, " R6 return port and cycle"}, LINE_W'(v), LINE_W'(ev));
        act = (e.src == 2'd1) ? dma_rdata :
              (e.src == 2'd2) ? {{(LINE_W-QUAD_W){1'b0}}, lsu_rdata} : ifu_rdata;
        chk(act == e.data, {e.tag, " return data"}, act, e.data);
      end else if (v != 3'b000) begin
        chk(1'b0, "R8 unexpected read return", LINE_W'(v), '0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  logic [QUAD_W-1:0] qd;
  logic [LINE_W-1:0] ld;

  initial begin
    for (int i = 0; i < NLINES; i++) begin
      sram[i]    = pattern(i);
      ref_mem[i] = pattern(i);
    end
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!mem_en, "R1 mem_en in reset", LINE_W'(mem_en), '0);
    chk({dma_rvalid, lsu_rvalid, ifu_rvalid} == 3'b000, "R1 rvalid in reset",
        LINE_W'({dma_rvalid, lsu_rvalid, ifu_rvalid}), '0);
    chk(ifu_starve == '0, "R1 starve in reset", LINE_W'(ifu_starve), '0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(!mem_en && ifu_starve == '0, "R1 first cycle after reset",
        LINE_W'({mem_en, ifu_starve}), '0);

    // R2: DMA alone, then all three contend
    set_dma(0, mkaddr(5, 0, 0), '0);                                  step("R2 dma read");
    set_dma(0, mkaddr(9, 0, 0), '0); set_lsu(0, mkaddr(3, 1, 0), '0);
    set_ifu(mkaddr(4, 0, 0));                                         step("R2 three-way contention");
    // R3: load wins over fetch; R7/R9 quadword 5 with low byte offset
    set_lsu(0, mkaddr(3, 5, 7), '0); set_ifu(mkaddr(4, 0, 0));        step("R3 R7 R9 load over fetch");
    // R4: fetch alone, low bits set (R9)
    set_ifu(mkaddr(6, 3, 9));                                         step("R4 R9 idle fetch");
    drain();

    // R5: store drives one quadword enable and places data in its lane
    qd = 128'hC0FFEE00_11223344_55667788_99AABBCC;
    set_lsu(1, mkaddr(20, 2, 5), qd);                                 step("R5 store");
    step("idle");
    chk(mem_en && mem_we && mem_idx == IDX_W'(20) && mem_qmask == 8'b0000_0100,
        "R5 store command", LINE_W'({mem_en, mem_we, mem_idx, mem_qmask}),
        LINE_W'({1'b1, 1'b1, IDX_W'(20), 8'b0000_0100}));
    chk(mem_wdata[2*QUAD_W +: QUAD_W] == qd, "R5 store lane", LINE_W'(mem_wdata[2*QUAD_W +: QUAD_W]), LINE_W'(qd));
    // R5/R9: line write with low bits set
    ld = ~pattern(777);
    set_dma(1, mkaddr(21, 3, 15), ld);                                step("R5 R9 line write");
    step("idle");
    chk(mem_en && mem_we && mem_idx == IDX_W'(21) && mem_qmask == 8'hFF,
        "R5 line write command", LINE_W'({mem_en, mem_we, mem_idx, mem_qmask}),
        LINE_W'({1'b1, 1'b1, IDX_W'(21), 8'hFF}));
    // R8: no return from writes
    repeat (RD_LAT) step("idle");
    chk({dma_rvalid, lsu_rvalid, ifu_rvalid} == 3'b000, "R8 no return after writes",
        LINE_W'({dma_rvalid, lsu_rvalid, ifu_rvalid}), '0);
    // Read back merged and written data
    set_dma(0, mkaddr(20, 7, 3), '0);                                 step("R7 merged line readback");
    set_lsu(0, mkaddr(20, 2, 15), '0);                                step("R7 R9 stored quadword");
    set_lsu(0, mkaddr(20, 3, 0), '0);                                 step("R7 neighbour quadword");
    set_ifu(mkaddr(21, 0, 1));                                        step("R9 fetch of written line");
    set_dma(0, mkaddr(21, 0, 127), '0);                               step("R9 dma low bits");
    drain();

    // R11: back-to-back reads from a mix of clients
    for (int i = 0; i < 9; i++) begin
      if (i % 3 == 0)      set_dma(0, mkaddr(100 + i, 0, 0), '0);
      else if (i % 3 == 1) set_lsu(0, mkaddr(100 + i, i % 8, 0), '0);
      else                 set_ifu(mkaddr(100 + i, 0, 0));
      step("R11 back-to-back");
    end
    drain();

    // R10: denial counting by DMA
    for (int i = 0; i < 5; i++) begin
      set_dma(1, mkaddr(40, 0, 0), pattern(40)); set_ifu(mkaddr(41, 0, 0));
      step("R10 denied by dma");
    end
    set_ifu(mkaddr(41, 0, 0));                                        step("R10 fetch granted");
    chk(ifu_starve == 8'd5, "R10 count after 5 denials", LINE_W'(ifu_starve), LINE_W'(5));
    step("idle");
    chk(ifu_starve == 8'd0, "R10 clear after grant", LINE_W'(ifu_starve), '0);
    // R10: denial by stores, then clear on withdrawal
    for (int i = 0; i < 3; i++) begin
      set_lsu(1, mkaddr(42, i, 0), 128'(i + 1)); set_ifu(mkaddr(41, 0, 0));
      step("R10 denied by store");
    end
    chk(ifu_starve == 8'd2, "R10 count during denial", LINE_W'(ifu_starve), LINE_W'(2));
    step("idle");
    chk(ifu_starve == 8'd3, "R10 count after withdrawal", LINE_W'(ifu_starve), LINE_W'(3));
    step("idle");
    chk(ifu_starve == 8'd0, "R10 clear without request", LINE_W'(ifu_starve), '0);
    // R10: saturation
    for (int i = 0; i < 300; i++) begin
      set_dma(1, mkaddr(40, 0, 0), pattern(40)); set_ifu(mkaddr(41, 0, 0));
      step("R10 long denial");
    end
    chk(ifu_starve == 8'hFF, "R10 saturation", LINE_W'(ifu_starve), LINE_W'(8'hFF));
    set_lsu(0, mkaddr(42, 1, 0), '0);                                 step("R7 stored quadword read");
    drain();
    chk(sb.size() == 0, "R6 all returns delivered", LINE_W'(sb.size()), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule